// File: doc/BRIEF.md
# Phase-Locked Harmonic Anti-Noise Synthesizer

This block produces a digital anti-noise waveform for a 14-bit DAC. The waveform is built as a sum of sine tones, one tone per harmonic slot k = 1..NH. Tone k runs at k times a programmable base frequency and carries its own amplitude and starting phase. Every tone is restarted at its programmed phase on each rising edge of a trigger that is taken from the converter's switching control signal. Because of this restart, the synthesized waveform stays phase-locked to the switching period.

An external trainer writes the coefficients into a bank of NSETS stored parameter sets through a simple write port. Each set holds NH amplitudes, NH phase offsets and one base increment. A mode input picks the set that drives synthesis. A playback option instead reads out one stored sampled waveform, one sample per output frame, starting again from its first sample on every trigger. The mode and playback selections, and any coefficient edits, only take effect at a trigger. As a result, one switching period never mixes two coefficient sets.

The tones are evaluated one after another through a single sine lookup and a single multiplier. This takes NH clock cycles per output sample. The sum is clamped to the signed 14-bit range, and a sticky flag records that clipping has happened.

Top module: `anc_tone_synth`

## Requirements
- R1: Each output sample equals the clamped sum over all slots k of floor(amp_k * s(p_k) / 2048). The sine value s(p) comes from the phase's top 8 bits q = p[31:24] as follows. Let x = q mod 128 and m = floor(x*(128-x)/2). Then s = m when q < 128 and s = -m otherwise. This gives s = +2048 at phase 0x40000000, s = -2048 at 0xC0000000 and s = 0 at phase 0.
- R2: In the n-th sample frame after a restart (n = 0 first), the phase of slot k (k = 1..NH) is (offset_k + n*k*base) mod 2^32.
- R3: A rising edge on `trig_in` is never lost. The first sample frame that begins after the edge has been registered is frame n = 0. With NH = 8 and the edge raised one cycle after a `dac_valid` pulse, this is the second `dac_valid` pulse after the edge.
- R4: `mode_sel` and `play_sel` are sampled only at a restart. Changing them at any other time has no effect on the output.
- R5: The write port stores data when `wr_en` is high. `wr_kind` selects the target: 0 = amplitude of slot `wr_addr`+1 (12 bits, unsigned), 1 = phase offset of slot `wr_addr`+1 (32 bits), 2 = base increment of set `wr_set` (32 bits), 3 = playback sample `wr_addr` (14 bits, signed, `wr_set` ignored). Writes into a stored set, including the active one, are seen by the output only from the next restart.
- R6: A sum above 8191 is output as 8191, and a sum below -8192 is output as -8192.
- R7: `clip_flag` rises after the first clamped sample and stays high until reset.
- R8: With playback selected, frame n outputs stored sample n for n < WAVE_DEPTH and 0 for later frames, until the next trigger.
- R9: After reset, `dac_out` is 0 and `clip_flag` is 0. `dac_valid` pulses for one cycle once every NH cycles, and the samples read 0 until a set with nonzero amplitude is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Switching trigger; the rising edge restarts all tones |
| mode_sel | input | SET_W | Stored set used from the next restart |
| play_sel | input | 1 | 1 = playback of the stored waveform from the next restart |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 amplitude, 1 phase, 2 base increment, 3 playback sample |
| wr_set | input | SET_W | Set addressed by kinds 0 to 2 |
| wr_addr | input | ADDR_W | Slot index (kinds 0, 1) or sample index (kind 3) |
| wr_data | input | 32 | Write data |
| dac_out | output | 14 | Signed output sample |
| dac_valid | output | 1 | One-cycle strobe for a new sample |
| clip_flag | output | 1 | Sticky clipping indicator |

## Verification
Some properties are checked every cycle by assertions. The strobe is spaced correctly. The clip flag never drops. A trigger edge always ends up as pending or restarted. Working coefficients and the latched mode change only at a restart. An oversized sum reaches the port as the clamp value. Playback beyond the stored length yields zero.

Other behaviour can only be shown by the bench's scenarios. These include the actual sample values across several harmonic mixes, the frame-accurate restart of every tone, and the deferral of mode changes and active-set writes until the next trigger. They also include playback ordering and the hold of the clip flag once sums return in range.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam int ACC_W    = 32;
  localparam int LUT_AW   = 8;
  localparam int SIN_FRAC = 11;
  localparam int SIN_W    = SIN_FRAC + 2;
  localparam int AMP_W    = 12;
  localparam int OUT_W    = 14;
  localparam int LUT_N    = 1 << LUT_AW;
  localparam int HALF_N   = LUT_N / 2;
  localparam int MAG_SH   = 2 * (LUT_AW - 1) - 2 - SIN_FRAC;
  localparam int OUT_MAX  = (1 << (OUT_W - 1)) - 1;
  localparam int OUT_MIN  = -(1 << (OUT_W - 1));

  // parabolic half-wave: exact zero at 0 and half, exact peak 2^SIN_FRAC at quarter
  function automatic logic signed [SIN_W-1:0] sine_at(input int idx);
    int x;
    int mag;
    x   = idx % HALF_N;
    mag = (x * (HALF_N - x)) >>> MAG_SH;
    if (((idx / HALF_N) % 2) == 1) mag = -mag;
    return SIN_W'(mag);
  endfunction

  function automatic logic signed [OUT_W-1:0] clamp_out(input int v);
    if (v > OUT_MAX) return OUT_W'(OUT_MAX);
    if (v < OUT_MIN) return OUT_W'(OUT_MIN);
    return OUT_W'(v);
  endfunction

  function automatic logic clipped(input int v);
    return (v > OUT_MAX) || (v < OUT_MIN);
  endfunction
endpackage

// File: rtl/anc_sine_rom.sv
module anc_sine_rom
  import anc_pkg::*;
(
  input  logic                     clk,
  input  logic [LUT_AW-1:0]        addr,
  output logic signed [SIN_W-1:0]  q
);
  logic signed [SIN_W-1:0] tbl [LUT_N];

  for (genvar i = 0; i < LUT_N; i++) begin : g_ent
    assign tbl[i] = sine_at(i);
  end

  always_ff @(posedge clk) q <= tbl[addr];
endmodule

// File: rtl/anc_frame_ctl.sv
module anc_frame_ctl
  import anc_pkg::*;
#(
  parameter int NH         = 8,
  parameter int WAVE_DEPTH = 64,
  parameter int SET_W      = 1,
  parameter int SLOT_W     = $clog2(NH),
  parameter int PN_W       = $clog2(WAVE_DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [SET_W-1:0]  mode_sel,
  input  logic              play_sel,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_end,
  output logic              restart_load,
  output logic              restart_f,
  output logic              play_act,
  output logic [PN_W-1:0]   play_n
);
  logic             trig_q;
  logic             pend_q;
  logic             trig_edge;
  logic [SET_W-1:0] act_set;

  assign trig_edge    = trig_in & ~trig_q;
  assign frame_end    = (slot == SLOT_W'(NH - 1));
  assign restart_load = frame_end & (pend_q | trig_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot      <= '0;
      trig_q    <= 1'b0;
      pend_q    <= 1'b0;
      restart_f <= 1'b0;
      play_act  <= 1'b0;
      act_set   <= '0;
      play_n    <= '0;
    end else begin
      trig_q <= trig_in;
      slot   <= frame_end ? '0 : slot + SLOT_W'(1);
      pend_q <= frame_end ? 1'b0 : (pend_q | trig_edge);
      if (frame_end) restart_f <= restart_load;
      if (restart_load) begin
        act_set  <= mode_sel;
        play_act <= play_sel;
        play_n   <= '0;
      end else if (frame_end && int'(play_n) < WAVE_DEPTH) begin
        play_n <= play_n + PN_W'(1);
      end
    end
  end

  // R3
  trig_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> (pend_q || restart_f));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_load |=> ($stable(act_set) && $stable(play_act)));
endmodule

// File: rtl/anc_param_bank.sv
module anc_param_bank
  import anc_pkg::*;
#(
  parameter int NH         = 8,
  parameter int NSETS      = 2,
  parameter int WAVE_DEPTH = 64,
  parameter int SET_W      = 1,
  parameter int ADDR_W     = 6,
  parameter int PN_W       = $clog2(WAVE_DEPTH + 1)
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [1:0]                       wr_kind,
  input  logic [SET_W-1:0]                 wr_set,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [31:0]                      wr_data,
  input  logic                             load,
  input  logic [SET_W-1:0]                 load_set,
  input  logic [PN_W-1:0]                  play_n,
  output logic [NH-1:0][AMP_W-1:0]         work_amp,
  output logic [NH-1:0][ACC_W-1:0]         work_ph,
  output logic [ACC_W-1:0]                 work_inc,
  output logic signed [OUT_W-1:0]          wave_smp
);
  localparam int HI_W = $clog2(NH);
  localparam int WA_W = $clog2(WAVE_DEPTH);

  logic [AMP_W-1:0]        amp_mem  [NSETS][NH];
  logic [ACC_W-1:0]        ph_mem   [NSETS][NH];
  logic [ACC_W-1:0]        inc_mem  [NSETS];
  logic signed [OUT_W-1:0] wave_mem [WAVE_DEPTH];

  logic set_ok, slot_ok;
  assign set_ok  = int'(wr_set) < NSETS;
  assign slot_ok = int'(wr_addr) < NH;

  always_ff @(posedge clk) begin
    if (wr_en && set_ok) begin
      case (wr_kind)
        2'd0: if (slot_ok) amp_mem[wr_set][wr_addr[HI_W-1:0]] <= wr_data[AMP_W-1:0];
        2'd1: if (slot_ok) ph_mem[wr_set][wr_addr[HI_W-1:0]]  <= wr_data;
        2'd2: inc_mem[wr_set] <= wr_data;
        default: ;
      endcase
    end
    if (wr_en && wr_kind == 2'd3 && int'(wr_addr) < WAVE_DEPTH)
      wave_mem[wr_addr[WA_W-1:0]] <= wr_data[OUT_W-1:0];
  end

  // working copy: the only coefficients the datapath sees
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_amp <= '0;
      work_ph  <= '0;
      work_inc <= '0;
    end else if (load && int'(load_set) < NSETS) begin
      for (int k = 0; k < NH; k++) begin
        work_amp[k] <= amp_mem[load_set][k];
        work_ph[k]  <= ph_mem[load_set][k];
      end
      work_inc <= inc_mem[load_set];
    end
  end

  assign wave_smp = (int'(play_n) < WAVE_DEPTH) ? wave_mem[play_n[WA_W-1:0]] : '0;

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(work_amp) && $stable(work_ph) && $stable(work_inc)));

  // R8
  play_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(play_n) >= WAVE_DEPTH) |-> (wave_smp == '0));
endmodule

// File: rtl/anc_mac_pipe.sv
module anc_mac_pipe
  import anc_pkg::*;
#(
  parameter int NH     = 8,
  parameter int SLOT_W = $clog2(NH)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOT_W-1:0]         slot,
  input  logic                      frame_end,
  input  logic                      restart_f,
  input  logic [NH-1:0][AMP_W-1:0]  work_amp,
  input  logic [NH-1:0][ACC_W-1:0]  work_ph,
  input  logic [ACC_W-1:0]          work_inc,
  input  logic                      play_act,
  input  logic signed [OUT_W-1:0]   wave_smp,
  output logic signed [OUT_W-1:0]   dac_out,
  output logic                      dac_valid,
  output logic                      clip_flag
);
  localparam int PROD_W = AMP_W + 1 + SIN_W;
  localparam int TONE_W = AMP_W + 2;
  localparam int SUM_W  = TONE_W + $clog2(NH) + 1;

  logic [ACC_W-1:0] acc [NH];
  logic [ACC_W-1:0] phase_now, harm_k, step;

  assign phase_now = restart_f ? work_ph[slot] : acc[slot];
  assign harm_k    = ACC_W'(slot) + ACC_W'(1);
  assign step      = work_inc * harm_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NH; k++) acc[k] <= '0;
    end else begin
      acc[slot] <= phase_now + step;
    end
  end

  // stage A: sine lookup with side information
  logic signed [SIN_W-1:0] sine_a;
  logic [AMP_W-1:0]        amp_a;
  logic                    vld_a, first_a, last_a, play_a;
  logic signed [OUT_W-1:0] wave_a;

  anc_sine_rom u_rom (
    .clk  (clk),
    .addr (phase_now[ACC_W-1 -: LUT_AW]),
    .q    (sine_a)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_a <= 1'b0; first_a <= 1'b0; last_a <= 1'b0; play_a <= 1'b0;
      amp_a <= '0;   wave_a  <= '0;
    end else begin
      vld_a   <= 1'b1;
      first_a <= (slot == '0);
      last_a  <= frame_end;
      play_a  <= play_act;
      amp_a   <= work_amp[slot];
      wave_a  <= wave_smp;
    end
  end

  // stage B: scale
  logic signed [PROD_W-1:0] prod_w;
  logic signed [TONE_W-1:0] tone_b;
  logic                     vld_b, first_b, last_b, play_b;
  logic signed [OUT_W-1:0]  wave_b;

  assign prod_w = PROD_W'($signed({1'b0, amp_a})) * PROD_W'(sine_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_b <= 1'b0; first_b <= 1'b0; last_b <= 1'b0; play_b <= 1'b0;
      tone_b <= '0;  wave_b  <= '0;
    end else begin
      vld_b   <= vld_a;
      first_b <= first_a;
      last_b  <= last_a;
      play_b  <= play_a;
      tone_b  <= TONE_W'(prod_w >>> SIN_FRAC);
      wave_b  <= wave_a;
    end
  end

  // stage C: accumulate and clamp
  logic signed [SUM_W-1:0] sum_q, total;
  logic                    frame_done;
  assign total      = (first_b ? '0 : sum_q) + SUM_W'(tone_b);
  assign frame_done = vld_b && last_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q     <= '0;
      dac_out   <= '0;
      dac_valid <= 1'b0;
      clip_flag <= 1'b0;
    end else begin
      if (vld_b) sum_q <= total;
      dac_valid <= frame_done;
      if (frame_done) begin
        dac_out <= play_b ? wave_b : clamp_out(int'(total));
        if (!play_b && clipped(int'(total))) clip_flag <= 1'b1;
      end
    end
  end

  // R9
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);

  // R7
  clip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clip_flag |=> clip_flag);

  // R6
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !play_b && int'(total) > OUT_MAX) |=> (int'(dac_out) == OUT_MAX && clip_flag));

  // R6
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !play_b && int'(total) < OUT_MIN) |=> (int'(dac_out) == OUT_MIN && clip_flag));
endmodule

// File: rtl/anc_tone_synth.sv
module anc_tone_synth
  import anc_pkg::*;
#(
  parameter int NH         = 8,
  parameter int NSETS      = 2,
  parameter int WAVE_DEPTH = 64,
  parameter int SET_W      = (NSETS > 1) ? $clog2(NSETS) : 1,
  parameter int ADDR_W     = ($clog2(NH) > $clog2(WAVE_DEPTH)) ? $clog2(NH) : $clog2(WAVE_DEPTH)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_in,
  input  logic [SET_W-1:0]         mode_sel,
  input  logic                     play_sel,
  input  logic                     wr_en,
  input  logic [1:0]               wr_kind,
  input  logic [SET_W-1:0]         wr_set,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  output logic signed [OUT_W-1:0]  dac_out,
  output logic                     dac_valid,
  output logic                     clip_flag
);
  localparam int SLOT_W = $clog2(NH);
  localparam int PN_W   = $clog2(WAVE_DEPTH + 1);

  logic [SLOT_W-1:0]         slot;
  logic                      frame_end, restart_load, restart_f, play_act;
  logic [PN_W-1:0]           play_n;
  logic [NH-1:0][AMP_W-1:0]  work_amp;
  logic [NH-1:0][ACC_W-1:0]  work_ph;
  logic [ACC_W-1:0]          work_inc;
  logic signed [OUT_W-1:0]   wave_smp;

  anc_frame_ctl #(.NH(NH), .WAVE_DEPTH(WAVE_DEPTH), .SET_W(SET_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .mode_sel(mode_sel),
    .play_sel(play_sel), .slot(slot), .frame_end(frame_end),
    .restart_load(restart_load), .restart_f(restart_f),
    .play_act(play_act), .play_n(play_n)
  );

  anc_param_bank #(.NH(NH), .NSETS(NSETS), .WAVE_DEPTH(WAVE_DEPTH),
                   .SET_W(SET_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_set(wr_set), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(restart_load), .load_set(mode_sel), .play_n(play_n),
    .work_amp(work_amp), .work_ph(work_ph), .work_inc(work_inc),
    .wave_smp(wave_smp)
  );

  anc_mac_pipe #(.NH(NH)) u_mac (
    .clk(clk), .rst_n(rst_n), .slot(slot), .frame_end(frame_end),
    .restart_f(restart_f), .work_amp(work_amp), .work_ph(work_ph),
    .work_inc(work_inc), .play_act(play_act), .wave_smp(wave_smp),
    .dac_out(dac_out), .dac_valid(dac_valid), .clip_flag(clip_flag)
  );
endmodule

// File: tb/anc_tone_synth_tb.sv
module anc_tone_synth_tb;
  localparam int NH = 8;
  localparam int NSETS = 2;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic play_sel = 1'b0;
  logic [0:0] mode_sel = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [0:0] wr_set = '0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic signed [13:0] dac_out;
  logic dac_valid, clip_flag;

  anc_tone_synth u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .mode_sel(mode_sel),
    .play_sel(play_sel), .wr_en(wr_en), .wr_kind(wr_kind), .wr_set(wr_set),
    .wr_addr(wr_addr), .wr_data(wr_data), .dac_out(dac_out),
    .dac_valid(dac_valid), .clip_flag(clip_flag)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int unsigned m_amp [NSETS][NH];
  int unsigned m_ph  [NSETS][NH];
  int unsigned m_inc [NSETS];
  int          m_wave[DEPTH];

  typedef struct { int val; string tag; } exp_t;
  exp_t sb_q[$];
  int skip = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sine_ref(int unsigned ph);
    int q, x, m;
    q = int'(ph >> 24);
    x = q % 128;
    m = (x * (128 - x)) / 2;
    return (q >= 128) ? -m : m;
  endfunction

  function automatic int sample_ref(int set, int n);
    longint s = 0;
    for (int k = 0; k < NH; k++) begin
      int unsigned ph;
      longint t;
      ph = m_ph[set][k] + int'(n) * (k + 1) * m_inc[set];
      t  = longint'(m_amp[set][k]) * longint'(sine_ref(ph));
      s += t >>> 11;
    end
    if (s > 8191) return 8191;
    if (s < -8192) return -8192;
    return int'(s);
  endfunction

  // monitor: pops expected items as samples appear
  always @(negedge clk) begin
    if (rst_n && dac_valid) begin
      if (skip > 0) skip--;
      else if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, int'(dac_out), e.val);
      end
    end
  end

  task automatic wr(int kind, int set, int addr, int unsigned data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_set = 1'(set); wr_addr = 6'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      0: m_amp[set][addr] = data & 32'hFFF;
      1: m_ph[set][addr] = data;
      2: m_inc[set] = data;
      default: m_wave[addr] = int'(14'(data)) - ((data & 32'h2000) != 0 ? 16384 : 0);
    endcase
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  task automatic push(int v, string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // raise trigger one cycle after a strobe; the second strobe after it is frame 0
  task automatic fire(int set, bit play, int cnt, string tag);
    @(negedge clk);
    while (dac_valid !== 1'b1) @(negedge clk);
    @(posedge clk); #1;
    sb_q.delete();
    mode_sel = 1'(set); play_sel = play;
    trig = 1'b1; skip = 1;
    for (int n = 0; n < cnt; n++) begin
      if (play) push((n < DEPTH) ? m_wave[n] : 0, tag);
      else      push(sample_ref(set, n), tag);
    end
    repeat (3) @(posedge clk);
    #1 trig = 1'b0;
    drain();
  endtask

  task automatic clear_set(int set);
    for (int k = 0; k < NH; k++) begin
      wr(0, set, k, 0);
      wr(1, set, k, 0);
    end
    wr(2, set, 0, 0);
  endtask

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      m_inc[s] = 0;
      for (int k = 0; k < NH; k++) begin m_amp[s][k] = 0; m_ph[s][k] = 0; end
    end
    for (int i = 0; i < DEPTH; i++) m_wave[i] = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset dac_out", int'(dac_out), 0);
    check("R9 reset clip_flag", int'(clip_flag), 0);
    for (int i = 0; i < 3; i++) push(0, "R9 idle sample");
    drain();
    // strobe spacing
    begin
      int gap = 0;
      @(negedge clk); while (!dac_valid) @(negedge clk);
      @(negedge clk); gap = 1;
      while (!dac_valid) begin @(negedge clk); gap++; end
      check("R9 strobe period", gap, NH);
    end

    clear_set(0);
    clear_set(1);

    // R1: constant mix at exact sine points: +1000 - 500 + 0
    wr(0, 0, 0, 1000); wr(1, 0, 0, 32'h4000_0000);
    wr(0, 0, 1, 500);  wr(1, 0, 1, 32'hC000_0000);
    wr(0, 0, 2, 700);  wr(1, 0, 2, 32'h0000_0000);
    check("R1 model const", sample_ref(0, 0), 500);
    fire(0, 0, 6, "R1 const mix");
    check("R7 no clip in range", int'(clip_flag), 0);

    // R2: moving harmonics
    wr(2, 0, 0, 32'h00C0_0000);
    wr(0, 0, 1, 600); wr(1, 0, 1, 32'h2000_0000);
    wr(0, 0, 2, 0);
    wr(0, 0, 4, 300); wr(1, 0, 4, 32'h8000_0000);
    wr(0, 0, 7, 200); wr(1, 0, 7, 32'h1000_0000);
    fire(0, 0, 40, "R2 harmonic sweep");
    // R3: retrigger restarts every tone at its offset
    fire(0, 0, 12, "R3 retrigger");

    // R4 / R5: deferral of mode change and active-set writes
    clear_set(0);
    wr(0, 0, 0, 1000); wr(1, 0, 0, 32'h4000_0000);
    wr(0, 0, 1, 500);  wr(1, 0, 1, 32'hC000_0000);
    wr(0, 1, 0, 2000); wr(1, 1, 0, 32'h4000_0000);
    fire(0, 0, 4, "R1 set0 before mode test");
    for (int i = 0; i < 4; i++) push(500, "R4 mode change without trigger");
    mode_sel = 1'b1;
    drain();
    for (int i = 0; i < 4; i++) push(500, "R5 active-set write deferred");
    wr(0, 0, 0, 3000);
    drain();
    fire(1, 0, 4, "R4 set1 after trigger");
    fire(0, 0, 4, "R5 new set0 amplitude after trigger");
    check("R5 model", sample_ref(0, 0), 2500);

    // R6 / R7: saturation both ways, then sticky flag
    wr(0, 1, 0, 4000); wr(0, 1, 1, 4000); wr(0, 1, 2, 4000);
    wr(1, 1, 1, 32'h4000_0000); wr(1, 1, 2, 32'h4000_0000);
    fire(1, 0, 4, "R6 positive clamp");
    check("R6 model hi", sample_ref(1, 0), 8191);
    check("R7 clip set", int'(clip_flag), 1);
    for (int k = 0; k < 3; k++) wr(1, 1, k, 32'hC000_0000);
    fire(1, 0, 4, "R6 negative clamp");
    check("R6 model lo", sample_ref(1, 0), -8192);
    wr(0, 1, 0, 100); wr(0, 1, 1, 0); wr(0, 1, 2, 0);
    fire(1, 0, 4, "R7 in-range after clip");
    check("R7 clip sticky", int'(clip_flag), 1);

    // R8: playback of stored samples, then zero tail
    for (int i = 0; i < DEPTH; i++) wr(3, 0, i, 32'(i * 200 - 6000));
    fire(0, 1, DEPTH + 4, "R8 playback");
    fire(0, 0, 4, "R4 back to synthesis");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule